// File: doc/BRIEF.md
# Cartridge ROM Command Responder

This block is the card side of a game-card bus. A host presents an 8-byte command block and a transfer length in bytes. The responder then returns that many bytes as a stream of 32-bit words on a valid/ready output, and pulses a done flag after the last word. The first command byte selects the opcode. The response comes from an internal read-only image, a fixed chip identifier, a constant fill, or a small status register. That register is present only on the NAND-equipped flavour.

The cartridge flavour is fixed at build time by a parameter: 0 = retail, 1 = homebrew, 2 = NAND-equipped. The flavours differ in two ways. Homebrew data reads have no low-address redirection. Only the NAND flavour implements the status opcodes. The ROM image is a computed pattern whose size is a power of two set by a parameter, so no memory content is stored.

Top module: `cart_cmd_responder`

## Requirements
- R1: After reset, `out_valid` and `done` are 0.
- R2: Command byte n is `cmd_bytes[8n+7:8n]`, and byte 0 is the opcode. A command is accepted on a clock edge where `cmd_valid` is 1 and no transfer is in progress. The transfer has `xfer_len >> 2` words, because the two low length bits are ignored. One word is consumed on each edge where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, the word is held stable. Within a word, transfer byte 4w+j sits at `out_data[8j+7:8j]`.
- R3: `done` is high for exactly one cycle. That cycle is the one after the edge that consumed the last word. For a zero-word transfer, it is the cycle after acceptance. `out_valid` is 0 while `done` is 1.
- R4: A `cmd_valid` pulse during a transfer is ignored, and the running response continues unchanged.
- R5: The ROM byte at address a is `m[7:0]^m[15:8]^m[23:16]^m[31:24]^0x5A`, where m is a masked with (2^ROM_AW − 1). Every ROM read applies this mask.
- R6: Opcode 0xB7 reads ROM from a start address made of command bytes 1..4, with byte 1 as the most significant byte.
- R7: On retail and NAND flavours, a 0xB7 read applies a redirection after masking. A masked start below 0x8000 becomes 0x8000 plus its low 9 bits. Homebrew applies no redirection.
- R8: A 0xB7 read is split in two parts. The first part covers the bytes up to the end of the start address's 4 KiB page. The second part starts at the next page boundary. Each part applies the mask and the redirection to its own start address, then reads contiguously from that point.
- R9: Opcode 0x9F returns 0xFF in every byte.
- R10: Opcodes 0x90 and 0xB8 return the chip ID parameter in every word.
- R11: Opcode 0x00 returns transfer byte i from ROM address i mod 4096. The first 4 KiB therefore repeats to fill the length.
- R12: On the NAND flavour, opcode 0x94 clears an 8-bit status register, and opcode 0xB2 sets its bit 5. Both return zero words. The register is 0 after reset.
- R13: On the NAND flavour, opcode 0xD6 returns the status byte in all four bytes of every word. On other flavours, 0x94, 0xB2 and 0xD6 are unrecognised.
- R14: Any unrecognised opcode returns zero words for the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_bytes | input | 64 | Command block, byte n at bits 8n+7:8n |
| xfer_len | input | LEN_W | Transfer length in bytes |
| out_ready | input | 1 | Consumer accepts a word |
| out_valid | output | 1 | Response word present |
| out_data | output | 32 | Response word |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The embedded properties check several things on every cycle. They check that a stalled word stays stable, and that `done` never coincides with `out_valid`. They check that a command arriving mid-transfer leaves the captured opcode, address and length unchanged, and that the status register moves only at acceptance. They also check the constant-fill, chip-ID and zero-fill opcodes against the captured opcode. The address arithmetic can only be shown by the bench's scenarios, which run all three flavours side by side. That arithmetic covers masking, low-address redirection, the 4 KiB split, including wrap past the top of the address space, and the repeating header. The same applies to the word count with random ready stalls and to the status sequence of the NAND opcodes.

// File: rtl/cart_cmd_responder.sv
module cart_cmd_responder #(
  parameter int          FLAVOR  = 0,
  parameter int          ROM_AW  = 16,
  parameter int          LEN_W   = 16,
  parameter logic [31:0] CHIP_ID = 32'h00A5_3C1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [63:0]       cmd_bytes,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              done
);
  localparam int          WW       = LEN_W - 2;
  localparam logic [31:0] MASK     = (ROM_AW >= 32) ? 32'hFFFF_FFFF : ((32'd1 << ROM_AW) - 32'd1);
  localparam bit          REDIR    = (FLAVOR != 1);
  localparam bit          HAS_NAND = (FLAVOR == 2);

  logic          busy, done_q;
  logic [7:0]    op_q, status_q;
  logic [31:0]   start_q;
  logic [WW-1:0] idx_q, last_q;

  wire [WW-1:0] nwords = xfer_len[LEN_W-1:2];
  wire          accept = cmd_valid && !busy;
  wire          fire   = busy && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= 8'h00;
      start_q  <= 32'h0;
      idx_q    <= '0;
      last_q   <= '0;
      status_q <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q    <= cmd_bytes[7:0];
        start_q <= {cmd_bytes[15:8], cmd_bytes[23:16], cmd_bytes[31:24], cmd_bytes[39:32]};
        idx_q   <= '0;
        last_q  <= nwords - 1'b1;
        if (nwords == '0) done_q <= 1'b1;
        else              busy   <= 1'b1;
        if (HAS_NAND) begin
          if (cmd_bytes[7:0] == 8'h94)      status_q <= 8'h00;
          else if (cmd_bytes[7:0] == 8'hB2) status_q <= status_q | 8'h20;
        end
      end else if (fire) begin
        if (idx_q == last_q) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  function automatic logic [7:0] rom_byte(input logic [31:0] a);
    logic [31:0] m;
    m = a & MASK;
    return m[7:0] ^ m[15:8] ^ m[23:16] ^ m[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] resp_byte(input logic [7:0] op, input logic [31:0] st,
                                           input logic [31:0] off, input logic [7:0] stat,
                                           input int j);
    logic [31:0] first, ps, k, pm;
    first = 32'h1000 - {20'h0, st[11:0]};
    if (off >= first) begin
      ps = st + first;
      k  = off - first;
    end else begin
      ps = st;
      k  = off;
    end
    pm = ps & MASK;
    if (REDIR && pm < 32'h8000) pm = 32'h8000 + {23'h0, pm[8:0]};
    case (op)
      8'h9F:        return 8'hFF;
      8'h90, 8'hB8: return CHIP_ID[8*j +: 8];
      8'h00:        return rom_byte({20'h0, off[11:0]});
      8'hB7:        return rom_byte(pm + k);
      8'hD6:        return HAS_NAND ? stat : 8'h00;
      default:      return 8'h00;
    endcase
  endfunction

  for (genvar j = 0; j < 4; j++) begin : g_lane
    wire [31:0] off = 32'(idx_q) * 32'd4 + 32'(j);
    assign out_data[8*j +: 8] = resp_byte(op_q, start_q, off, status_q, j);
  end

  assign out_valid = busy;
  assign done      = done_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_done_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> $stable(op_q) && $stable(start_q) && $stable(last_q));
  p_fill_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == 8'h9F |-> out_data == 32'hFFFF_FFFF);
  p_chip_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == 8'h90 || op_q == 8'hB8) |-> out_data == CHIP_ID);
  p_status_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !busy) |=> $stable(status_q));
  p_unknown_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(op_q inside {8'h9F, 8'h90, 8'hB8, 8'h00, 8'hB7, 8'hD6}) |-> out_data == 32'h0);
endmodule

// File: tb/sim_cart_cmd_responder.sv
module sim_cart_cmd_responder;
  localparam logic [31:0] CHIP = 32'h00A5_3C1E;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] cmd_bytes = '0;
  logic [15:0] xfer_len = '0;
  logic [2:0]  ov, dn;
  logic [31:0] od [3];
  int errors = 0, checks = 0;
  logic [7:0] stat_m = 8'h00;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cart_cmd_responder #(.FLAVOR(0), .ROM_AW(16), .LEN_W(16), .CHIP_ID(CHIP)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_bytes, .xfer_len, .out_ready,
    .out_valid(ov[0]), .out_data(od[0]), .done(dn[0]));
  cart_cmd_responder #(.FLAVOR(1), .ROM_AW(16), .LEN_W(16), .CHIP_ID(CHIP)) u1 (
    .clk, .rst_n, .cmd_valid, .cmd_bytes, .xfer_len, .out_ready,
    .out_valid(ov[1]), .out_data(od[1]), .done(dn[1]));
  cart_cmd_responder #(.FLAVOR(2), .ROM_AW(16), .LEN_W(16), .CHIP_ID(CHIP)) u2 (
    .clk, .rst_n, .cmd_valid, .cmd_bytes, .xfer_len, .out_ready,
    .out_valid(ov[2]), .out_data(od[2]), .done(dn[2]));

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ebyte(input int fl, input logic [7:0] op, input logic [31:0] st,
                                       input int i, input logic [7:0] stat);
    int first, k;
    logic [31:0] ps;
    if (op == 8'h9F) return 8'hFF;
    if (op == 8'h90 || op == 8'hB8) return CHIP[8*(i%4) +: 8];
    if (op == 8'h00) return mbyte(32'(i % 4096));
    if (op == 8'hD6) return (fl == 2) ? stat : 8'h00;
    if (op != 8'hB7) return 8'h00;
    first = 4096 - int'(st[11:0]);
    if (i < first) begin ps = st; k = i; end
    else begin ps = st + 32'(first); k = i - first; end
    ps = ps & 32'hFFFF;
    if (fl != 1 && ps < 32'h8000) ps = 32'h8000 | (ps & 32'h1FF);
    return mbyte(ps + 32'(k));
  endfunction

  function automatic logic [31:0] eword(input int fl, input logic [7:0] op, input logic [31:0] st,
                                        input int w, input logic [7:0] stat);
    return {ebyte(fl, op, st, 4*w+3, stat), ebyte(fl, op, st, 4*w+2, stat),
            ebyte(fl, op, st, 4*w+1, stat), ebyte(fl, op, st, 4*w, stat)};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h9F: return "R9";
      8'h90, 8'hB8: return "R10";
      8'h00: return "R11";
      8'hB7: return "R5 R6 R7 R8";
      8'h94, 8'hB2: return "R12";
      8'hD6: return "R13";
      default: return "R14";
    endcase
  endfunction

  task automatic run(input logic [7:0] op, input logic [31:0] addr, input int len, input bit intrude);
    int nw, w, cyc;
    string tg;
    tg = tag_of(op);
    nw = (len % 65536) / 4;
    cmd_bytes = {$urandom(), $urandom()};
    cmd_bytes[39:0] = {addr[7:0], addr[15:8], addr[23:16], addr[31:24], op};
    xfer_len  = 16'(len);
    cmd_valid = 1'b1;
    if (op == 8'h94) stat_m = 8'h00;
    else if (op == 8'hB2) stat_m = stat_m | 8'h20;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (nw == 0) begin
      for (int d = 0; d < 3; d++) chk(dn[d] && !ov[d], "R3 zero-length done", {31'h0, dn[d]}, 32'h1);
    end
    w = 0; cyc = 0;
    while (w < nw && cyc < 20000) begin
      for (int d = 0; d < 3; d++) begin
        logic [31:0] e;
        e = eword(d, op, addr, w, stat_m);
        chk(ov[d] === 1'b1, "R2 word valid", {31'h0, ov[d]}, 32'h1);
        chk(od[d] === e, tg, od[d], e);
      end
      out_ready = ($urandom() % 4) != 0;
      if (intrude && w == 1) begin
        cmd_bytes = {$urandom(), $urandom()};
        cmd_bytes[7:0] = 8'h90;
        xfer_len  = 16'd4;
        cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      if (out_ready) w++;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    out_ready = 1'b0;
    if (nw > 0) begin
      chk(cyc < 20000, "R2 transfer stalled", 32'(cyc), 32'(nw));
      for (int d = 0; d < 3; d++) chk(dn[d] && !ov[d], "R3 done after last word", {30'h0, ov[d], dn[d]}, 32'h1);
    end
    @(negedge clk);
    for (int d = 0; d < 3; d++) chk(!dn[d] && !ov[d], "R3 done single pulse", {30'h0, ov[d], dn[d]}, 32'h0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [10];
    void'($urandom(32'd20240517));
    pool = '{8'h9F, 8'h90, 8'hB8, 8'h00, 8'hB7, 8'hB7, 8'hD6, 8'hB2, 8'h94, 8'h3C};
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) chk(!ov[d] && !dn[d], "R1 reset outputs", {30'h0, ov[d], dn[d]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run(8'h9F, 32'h0, 16, 1'b0);
    run(8'h90, 32'h0, 8, 1'b0);
    run(8'hB8, 32'h0, 14, 1'b0);
    run(8'hB7, 32'h0001_2340, 64, 1'b0);
    run(8'hB7, 32'h0000_9000, 32, 1'b0);
    run(8'hB7, 32'h0000_8FF8, 32, 1'b0);
    run(8'hB7, 32'h0000_0FF0, 64, 1'b0);
    run(8'hB7, 32'hFFFF_FFF0, 48, 1'b0);
    run(8'hB7, 32'h0000_0000, 16, 1'b0);
    run(8'h00, 32'h0, 16'h1010, 1'b0);
    run(8'hD6, 32'h0, 8, 1'b0);
    run(8'hB2, 32'h0, 4, 1'b0);
    run(8'hD6, 32'h0, 8, 1'b0);
    run(8'h94, 32'h0, 8, 1'b0);
    run(8'hD6, 32'h0, 8, 1'b0);
    run(8'h55, 32'h0, 12, 1'b0);
    run(8'h9F, 32'h0, 0, 1'b0);
    run(8'hB7, 32'h0000_A124, 40, 1'b1);
    run(8'h00, 32'h0, 24, 1'b1);
    for (int n = 0; n < 60; n++) begin
      logic [7:0] op;
      op = pool[$urandom() % 10];
      run(op, $urandom(), int'($urandom() % 260), ($urandom() % 5) == 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule